// File: doc/BRIEF.md
# BCD Seven-Segment Decoder with Zero Blanking

This block turns one binary-coded decimal digit into seven active-low segment drives for a common-anode style display. Besides the plain digit lookup it has three controls: a forced-blank input that darkens the digit outright, a lamp-test input that lights every segment, and a zero-blank input paired with a zero-blank output. A digit that is zero while its zero-blank input is active stays dark and passes the active level on.

Several copies are strung together to form a multi-digit readout. In the integer part, the most significant digit has its zero-blank input tied active and each digit's zero-blank output feeds the next digit to its right, so zeros ahead of the first significant digit vanish. In the fractional part the chain runs the other way, from the rightmost digit leftward, so that zeros after the last significant fractional digit vanish. A zero that has a significant digit on its chain's upstream side is always shown. The block is purely combinational; every output follows its inputs in the same cycle.

Top module: `bcd_seg_decoder`

## Requirements
- R1: Output `segN` is active low, bit 0 driving segment a up to bit 6 driving segment g; with `biN`, `ltN` high and no zero blanking, digits 0 to 9 light (active-high hex, bit 6 = g): 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F.
- R2: Codes 10 to 15 light fixed non-decimal glyphs (active-high hex): 10=58, 11=4C, 12=62, 13=69, 14=78, 15=00 (dark).
- R3: With `biN` low all seven segments are dark (`segN` = 7F) whatever the digit, `ltN` and `rbiN`.
- R4: With `biN` high and `ltN` low all seven segments are lit (`segN` = 00) whatever the digit and `rbiN`.
- R5: With `biN` and `ltN` high, a digit of 0 with `rbiN` low gives a dark digit (`segN` = 7F).
- R6: A digit of 0 with `rbiN` high is shown as the zero glyph.
- R7: `rboN` is low exactly when the digit is 0 and `rbiN` is low, independent of `ltN` and `biN`.
- R8: In a chain where the leftmost digit's `rbiN` is tied low and each `rboN` drives the `rbiN` of the digit to its right, zeros left of the first nonzero digit are dark and all later digits, zeros included, are shown.
- R9: In a fractional chain where the rightmost digit's `rbiN` is tied low and each `rboN` drives the `rbiN` of the digit to its left, zeros right of the last nonzero digit are dark and all earlier digits are shown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| digit | input | 4 | BCD digit, weights 8-4-2-1 |
| rbiN | input | 1 | Zero-blank request from the upstream neighbour, active low |
| ltN | input | 1 | Lamp test, active low |
| biN | input | 1 | Forced blank, active low |
| segN | output | 7 | Segment drives a..g in bits 0..6, active low |
| rboN | output | 1 | Zero-blank pass-on to the downstream neighbour, active low |

## Verification
Every result of this block, the segment pattern and the zero-blank output alike, is due in the same cycle as the input change, with no register on the path, and across a chain the blanking decision ripples through all the digits combinationally. The bench therefore applies each stimulus just after a rising clock edge and samples at the following falling edge, half a period later, which leaves the whole chain time to settle. All 128 combinations of digit and control levels are swept on one copy, and separate integer and fractional chains are loaded with values whose expected blanking is worked out digit by digit in the bench.

// File: rtl/bcd_seg_pkg.sv
package bcd_seg_pkg;

  localparam int DIGIT_W = 4;
  localparam int SEG_W   = 7;

  // Decisions handed from the control to the datapath.
  typedef struct packed {
    logic blankAll;   // drive every segment dark
    logic lampAll;    // drive every segment lit
    logic zeroBlank;  // digit is a suppressed zero
  } segStrobe_t;

endpackage

// File: rtl/bcd_seg_ctrl.sv
module bcd_seg_ctrl
  import bcd_seg_pkg::*;
(
  input  logic [DIGIT_W-1:0] digit,
  input  logic               rbiN,
  input  logic               ltN,
  input  logic               biN,
  output segStrobe_t         strobe,
  output logic               rboN
);

  logic isZero;
  logic zeroHit;

  assign isZero  = (digit == '0);
  assign zeroHit = isZero && !rbiN;

  // Priority: forced blank, then lamp test, then zero suppression.
  always_comb begin
    strobe.blankAll  = !biN;
    strobe.lampAll   = biN && !ltN;
    strobe.zeroBlank = biN && ltN && zeroHit;
  end

  assign rboN = !zeroHit;

endmodule

// File: rtl/bcd_seg_path.sv
module bcd_seg_path
  import bcd_seg_pkg::*;
(
  input  logic [DIGIT_W-1:0] digit,
  input  segStrobe_t         strobe,
  output logic [SEG_W-1:0]   segN
);

  logic [SEG_W-1:0] glyphOn;

  // Active-high glyphs, bit 0 = a ... bit 6 = g.
  always_comb begin
    unique case (digit)
      4'd0:    glyphOn = 7'h3F;
      4'd1:    glyphOn = 7'h06;
      4'd2:    glyphOn = 7'h5B;
      4'd3:    glyphOn = 7'h4F;
      4'd4:    glyphOn = 7'h66;
      4'd5:    glyphOn = 7'h6D;
      4'd6:    glyphOn = 7'h7D;
      4'd7:    glyphOn = 7'h07;
      4'd8:    glyphOn = 7'h7F;
      4'd9:    glyphOn = 7'h6F;
      4'd10:   glyphOn = 7'h58;
      4'd11:   glyphOn = 7'h4C;
      4'd12:   glyphOn = 7'h62;
      4'd13:   glyphOn = 7'h69;
      4'd14:   glyphOn = 7'h78;
      default: glyphOn = 7'h00;
    endcase
  end

  for (genvar s = 0; s < SEG_W; s++) begin : g_seg
    always_comb begin
      if (strobe.blankAll || strobe.zeroBlank) segN[s] = 1'b1;
      else if (strobe.lampAll)                 segN[s] = 1'b0;
      else                                     segN[s] = !glyphOn[s];
    end
  end

endmodule

// File: rtl/bcd_seg_decoder.sv
module bcd_seg_decoder
  import bcd_seg_pkg::*;
(
  input  logic [DIGIT_W-1:0] digit,
  input  logic               rbiN,
  input  logic               ltN,
  input  logic               biN,
  output logic [SEG_W-1:0]   segN,
  output logic               rboN
);

  segStrobe_t strobe;

  bcd_seg_ctrl ctrl_i (
    .digit  (digit),
    .rbiN   (rbiN),
    .ltN    (ltN),
    .biN    (biN),
    .strobe (strobe),
    .rboN   (rboN)
  );

  bcd_seg_path path_i (
    .digit  (digit),
    .strobe (strobe),
    .segN   (segN)
  );

endmodule

// File: rtl/bcd_seg_decoder_chk.sv
module bcd_seg_decoder_chk
  import bcd_seg_pkg::*;
(
  input logic [DIGIT_W-1:0] digit,
  input logic               rbiN,
  input logic               ltN,
  input logic               biN,
  input logic [SEG_W-1:0]   segN,
  input logic               rboN
);

  always_comb begin
    if (!$isunknown({digit, rbiN, ltN, biN, segN, rboN})) begin
      // R3
      blank_forced_chk: assert (biN || segN == '1)
        else $error("forced blank not dark");
      // R4
      lamp_test_chk: assert (!biN || ltN || segN == '0)
        else $error("lamp test not fully lit");
      // R5
      zero_dark_chk: assert (!(biN && ltN && !rbiN && digit == '0) || segN == '1)
        else $error("suppressed zero lit");
      // R7
      ripple_out_chk: assert (rboN == !(digit == '0 && !rbiN))
        else $error("zero-blank output wrong");
      // R1
      digit_visible_chk: assert (!(biN && ltN && digit >= 4'd1 && digit <= 4'd14) || segN != '1)
        else $error("nonzero digit dark");
    end
  end

endmodule

bind bcd_seg_decoder bcd_seg_decoder_chk chk_i (.*);

// File: tb/bcd_seg_decoder_tb.sv
module bcd_seg_decoder_tb_top;

  logic clk = 1'b0;
  always #5 clk = ~clk;
  logic rst;

  int checks = 0;
  int errs   = 0;
  bit finished = 0;

  logic [3:0] digit;
  logic rbiN, ltN, biN;
  logic [6:0] segN;
  logic rboN;

  bcd_seg_decoder dut_i (
    .digit(digit), .rbiN(rbiN), .ltN(ltN), .biN(biN),
    .segN(segN), .rboN(rboN)
  );

  // Integer chain, index 0 is leftmost (R8)
  logic [3:0] leadDig [4];
  logic       leadRbi [4];
  logic       leadRbo [4];
  logic [6:0] leadSeg [4];
  // Fractional chain, index 0 is leftmost (R9)
  logic [3:0] fracDig [3];
  logic       fracRbi [3];
  logic       fracRbo [3];
  logic [6:0] fracSeg [3];

  for (genvar g = 0; g < 4; g++) begin : g_lead
    if (g == 0) begin : g_first
      assign leadRbi[g] = 1'b0;
    end else begin : g_rest
      assign leadRbi[g] = leadRbo[g-1];
    end
    bcd_seg_decoder lead_i (
      .digit(leadDig[g]), .rbiN(leadRbi[g]), .ltN(1'b1), .biN(1'b1),
      .segN(leadSeg[g]), .rboN(leadRbo[g])
    );
  end

  for (genvar g = 0; g < 3; g++) begin : g_frac
    if (g == 2) begin : g_last
      assign fracRbi[g] = 1'b0;
    end else begin : g_rest
      assign fracRbi[g] = fracRbo[g+1];
    end
    bcd_seg_decoder frac_i (
      .digit(fracDig[g]), .rbiN(fracRbi[g]), .ltN(1'b1), .biN(1'b1),
      .segN(fracSeg[g]), .rboN(fracRbo[g])
    );
  end

  function automatic logic [6:0] glyph(input logic [3:0] d);
    case (d)
      4'd0: return 7'h3F;  4'd1: return 7'h06;  4'd2: return 7'h5B;
      4'd3: return 7'h4F;  4'd4: return 7'h66;  4'd5: return 7'h6D;
      4'd6: return 7'h7D;  4'd7: return 7'h07;  4'd8: return 7'h7F;
      4'd9: return 7'h6F;  4'd10: return 7'h58; 4'd11: return 7'h4C;
      4'd12: return 7'h62; 4'd13: return 7'h69; 4'd14: return 7'h78;
      default: return 7'h00;
    endcase
  endfunction

  function automatic logic [6:0] expSeg(input logic [3:0] d, input logic rbi,
                                        input logic lt, input logic bi);
    if (!bi) return 7'h7F;
    if (!lt) return 7'h00;
    if (d == 4'd0 && !rbi) return 7'h7F;
    return ~glyph(d);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string reqOf(input logic [3:0] d, input logic rbi,
                                  input logic lt, input logic bi);
    if (!bi) return "R3";
    if (!lt) return "R4";
    if (d == 4'd0) return rbi ? "R6" : "R5";
    if (d >= 4'd10) return "R2";
    return "R1";
  endfunction

  task automatic runLead(input logic [15:0] val);
    bit dark;
    @(posedge clk);
    for (int k = 0; k < 4; k++) leadDig[k] = val[15-4*k -: 4];
    @(negedge clk);
    dark = 1;
    for (int k = 0; k < 4; k++) begin
      if (dark && leadDig[k] == 4'd0) check("R8", {1'b0, leadSeg[k]}, 8'h7F);
      else begin
        dark = 0;
        check("R8", {1'b0, leadSeg[k]}, {1'b0, ~glyph(leadDig[k])});
      end
    end
  endtask

  task automatic runFrac(input logic [11:0] val);
    bit dark;
    @(posedge clk);
    for (int k = 0; k < 3; k++) fracDig[k] = val[11-4*k -: 4];
    @(negedge clk);
    dark = 1;
    for (int k = 2; k >= 0; k--) begin
      if (dark && fracDig[k] == 4'd0) check("R9", {1'b0, fracSeg[k]}, 8'h7F);
      else begin
        dark = 0;
        check("R9", {1'b0, fracSeg[k]}, {1'b0, ~glyph(fracDig[k])});
      end
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++;
    errs++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish();
  end

  initial begin
    rst = 1'b1;
    digit = 4'd8; rbiN = 1'b1; ltN = 1'b1; biN = 1'b0;
    for (int k = 0; k < 4; k++) leadDig[k] = 4'd0;
    for (int k = 0; k < 3; k++) fracDig[k] = 4'd0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Initial state: forced blank held, display dark (R3)
    check("R3", {1'b0, segN}, 8'h7F);

    // Exhaustive sweep of one copy: R1..R7
    for (int v = 0; v < 128; v++) begin
      @(posedge clk);
      digit = v[3:0]; rbiN = v[4]; ltN = v[5]; biN = v[6];
      @(negedge clk);
      check(reqOf(digit, rbiN, ltN, biN), {1'b0, segN},
            {1'b0, expSeg(digit, rbiN, ltN, biN)});
      check("R7", {7'd0, rboN}, {7'd0, !(digit == 4'd0 && !rbiN)});
    end

    // Integer chains (R8)
    runLead(16'h0053);
    runLead(16'h0000);
    runLead(16'h0050);
    runLead(16'h1004);
    runLead(16'h0907);
    // Fractional chains (R9)
    runFrac(12'h700);
    runFrac(12'h070);
    runFrac(12'h000);
    runFrac(12'h305);
    runFrac(12'h009);
    finish();
  end

endmodule